// File: doc/BRIEF.md
# Indirect-Read Edge/Level Event Counter Bank

This block counts occurrences of on-chip events in a bank of eight 64-bit counters. A vector of 512 single-bit event lines enters the block. Each counter has its own configuration word, which names one of those lines by a 10-bit identifier and chooses how that line is counted. In edge mode a counter adds one for each transition into the active state. In level mode it adds one for every cycle the line sits at the active level. A polarity bit sets whether high or low is the active state.

A single control word governs the whole bank. Counting runs only while its enable and start bits are both set. A reset bit clears every counter at once. Because the counters are 64 bits wide, software never has to sample them on a schedule to catch a wrap.

Counter values are not placed in the register map. Software first writes a select register with 8 plus the counter number. It then reads the high word, which also captures the low word of the same counter, and then reads the low word. Because the low word was captured together with the high word, a carry between the two reads cannot tear the value.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset the control word, every configuration word and the select register read as zero, and every counter holds zero.
- R2: The configuration word of counter i is at byte offset 0x10C + 4*i. Bits [9:0] hold the event identifier, bit 10 is the polarity (1 = high is active, 0 = low is active) and bit 11 picks edge mode (1) or level mode (0). A read returns bits [11:0] as written and zero above them.
- R3: The control word is at 0x108, with bit 0 as enable and bit 1 as start. Counters advance only while both bits are 1. With either bit at 0 no counter changes, whatever the event lines do.
- R4: Writing the control word with bit 4 set clears all counters at the clock edge that takes the write. Bit 4 is not stored and reads back as 0. Bits 0 and 1 take the written values.
- R5: In edge mode with polarity 1, each 0-to-1 transition of the selected line adds exactly one. A line that stays high adds nothing more.
- R6: In edge mode with polarity 0, each 1-to-0 transition of the selected line adds exactly one.
- R7: In level mode, each enabled cycle in which the selected line equals the active level adds one.
- R8: An event identifier of 512 or more selects no line, and that counter never advances.
- R9: The select register at 0x12C reads back as written (8 bits). Values 8 to 15 choose counter value-8. A read at 0x134 returns bits [63:32] of the chosen counter.
- R10: A read at 0x134 captures bits [31:0] of the same counter. A later read at 0x130 returns that captured word, even if the counter has since advanced or the select has moved to another valid counter.
- R11: While the select register holds a value outside 8 to 15, reads at 0x130 and 0x134 both return zero.
- R12: Read data appears on the read data port in the cycle after the read request. Offsets outside the register map read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| evt_i | input | 512 | Event lines |

## Verification
The bench builds the block with its default parameters: eight counters, 64-bit width and 512 event lines. With these values every counter slot can be selected, including the out-of-range select values on either side of the valid window. Identifiers in the upper half of the 10-bit space can be checked against lines that share their low nine bits. At this width no carry into the high word can be reached, so the high word is always checked as zero. The capture on a high-word read is instead shown by reading the low word after the counter has moved on, and after the select has been switched to another counter.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

    localparam int REG_AW   = 12;
    localparam int REG_DW   = 32;
    localparam int ID_W     = 10;
    localparam int SEL_W    = 8;
    localparam int SEL_BASE = 8;

    localparam logic [REG_AW-1:0] ADR_CTL  = 12'h108;
    localparam logic [REG_AW-1:0] ADR_CFG0 = 12'h10C;
    localparam logic [REG_AW-1:0] ADR_SEL  = 12'h12C;
    localparam logic [REG_AW-1:0] ADR_LO   = 12'h130;
    localparam logic [REG_AW-1:0] ADR_HI   = 12'h134;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_GO_BIT  = 1;
    localparam int CTL_CLR_BIT = 4;

    // bit 11 edge mode, bit 10 polarity, bits 9:0 identifier
    typedef struct packed {
        logic            edge_mode;
        logic            active_high;
        logic [ID_W-1:0] id;
    } evcfg_t;

    localparam int CFG_W = $bits(evcfg_t);

    typedef struct packed {
        logic go;
        logic en;
    } ctl_t;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_CTL,
        RS_CFG,
        RS_SEL,
        RS_LO,
        RS_HI
    } rsrc_t;

    function automatic logic [REG_AW-1:0] cfg_addr(input int idx);
        return ADR_CFG0 + REG_AW'(4 * idx);
    endfunction

    function automatic logic [REG_DW-1:0] cfg_word(input evcfg_t c);
        return REG_DW'(c);
    endfunction

    function automatic logic [REG_DW-1:0] ctl_word(input ctl_t c);
        logic [REG_DW-1:0] w;
        w = '0;
        w[CTL_EN_BIT] = c.en;
        w[CTL_GO_BIT] = c.go;
        return w;
    endfunction

endpackage

// File: rtl/evcnt_regs.sv
module evcnt_regs
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [REG_AW-1:0]           wr_addr,
    input  logic [REG_DW-1:0]           wr_data,
    output ctl_t                        ctl_o,
    output logic                        clr_o,
    output evcfg_t [NUM_CNT-1:0]        cfg_o,
    output logic   [NUM_CNT-1:0]        cfg_wr_o,
    output logic   [SEL_W-1:0]          sel_o
);

    ctl_t              ctl_q;
    evcfg_t [NUM_CNT-1:0] cfg_q;
    logic [SEL_W-1:0]  sel_q;
    logic              ctl_wr;
    logic              sel_wr;
    logic              unused_hi_bits;

    assign ctl_wr = wr_en && (wr_addr == ADR_CTL);
    assign sel_wr = wr_en && (wr_addr == ADR_SEL);
    assign clr_o  = ctl_wr && wr_data[CTL_CLR_BIT];
    assign unused_hi_bits = ^wr_data[REG_DW-1:CFG_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q.en <= wr_data[CTL_EN_BIT];
            ctl_q.go <= wr_data[CTL_GO_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (sel_wr) begin
            sel_q <= wr_data[SEL_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cfg
        assign cfg_wr_o[g] = wr_en && (wr_addr == cfg_addr(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= '0;
            end else if (cfg_wr_o[g]) begin
                cfg_q[g] <= evcfg_t'(wr_data[CFG_W-1:0]);
            end
        end
    end

    assign ctl_o = ctl_q;
    assign cfg_o = cfg_q;
    assign sel_o = sel_q;

endmodule

// File: rtl/evcnt_detect.sv
module evcnt_detect
    import evcnt_pkg::*;
#(
    parameter int EVT_NUM = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [EVT_NUM-1:0] evt_i,
    input  evcfg_t             cfg_i,
    input  logic               cfg_wr_i,
    output logic               hit_o
);

    localparam int IDX_W = $clog2(EVT_NUM);

    logic             in_range;
    logic [IDX_W-1:0] line_idx;
    logic             active;
    logic             prev_q;

    assign in_range = (int'(cfg_i.id) < EVT_NUM);
    assign line_idx = cfg_i.id[IDX_W-1:0];
    assign active   = in_range && (evt_i[line_idx] == cfg_i.active_high);
    assign hit_o    = active && (!cfg_i.edge_mode || !prev_q);

    // prev is forced active on a config write so a new selection
    // does not count a transition against the previous line
    always_ff @(posedge clk) begin
        if (rst || cfg_wr_i) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= active;
        end
    end

    AST_EDGE_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (hit_o && cfg_i.edge_mode) |=> (!hit_o || !cfg_i.edge_mode)); // R5

endmodule

// File: rtl/evcnt_counters.sv
module evcnt_counters
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 64
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            run_i,
    input  logic                            clr_i,
    input  logic [NUM_CNT-1:0]              hit_i,
    output logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_o
);

    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                cnt_q[g] <= '0;
            end else if (run_i && hit_i[g]) begin
                cnt_q[g] <= cnt_q[g] + CNT_W'(1);
            end
        end

        AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
            (!run_i && !clr_i) |=> $stable(cnt_q[g])); // R3

        AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
            !clr_i |=> ((cnt_q[g] - $past(cnt_q[g])) <= CNT_W'(1))); // R7

        AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
            clr_i |=> (cnt_q[g] == '0)); // R4
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/evcnt_readout.sv
module evcnt_readout
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 64
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rd_en,
    input  logic [REG_AW-1:0]               rd_addr,
    input  ctl_t                            ctl_i,
    input  evcfg_t [NUM_CNT-1:0]            cfg_i,
    input  logic [SEL_W-1:0]                sel_i,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_i,
    output logic [REG_DW-1:0]               rd_data
);

    localparam int CIDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

    logic              sel_ok;
    logic [CIDX_W-1:0] sel_idx;
    logic [CNT_W-1:0]  cur;
    rsrc_t             src;
    logic [CIDX_W-1:0] cfg_idx;
    logic [REG_DW-1:0] nxt;
    logic [REG_DW-1:0] lo_q;
    logic [REG_DW-1:0] rd_q;

    assign sel_ok  = (sel_i >= SEL_W'(SEL_BASE)) && (sel_i < SEL_W'(SEL_BASE + NUM_CNT));
    assign sel_idx = CIDX_W'(sel_i - SEL_W'(SEL_BASE));
    assign cur     = sel_ok ? cnt_i[sel_idx] : '0;

    always_comb begin
        src     = RS_NONE;
        cfg_idx = '0;
        if (rd_addr == ADR_CTL) src = RS_CTL;
        if (rd_addr == ADR_SEL) src = RS_SEL;
        if (rd_addr == ADR_LO)  src = RS_LO;
        if (rd_addr == ADR_HI)  src = RS_HI;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (rd_addr == cfg_addr(i)) begin
                src     = RS_CFG;
                cfg_idx = CIDX_W'(i);
            end
        end
    end

    always_comb begin
        case (src)
            RS_CTL:  nxt = ctl_word(ctl_i);
            RS_CFG:  nxt = cfg_word(cfg_i[cfg_idx]);
            RS_SEL:  nxt = REG_DW'(sel_i);
            RS_HI:   nxt = REG_DW'(cur >> REG_DW);
            RS_LO:   nxt = sel_ok ? lo_q : '0;
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
            lo_q <= '0;
        end else if (rd_en) begin
            rd_q <= nxt;
            if (src == RS_HI) begin
                lo_q <= cur[REG_DW-1:0];
            end
        end
    end

    assign rd_data = rd_q;

    AST_OUT_OF_WINDOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !sel_ok && ((rd_addr == ADR_LO) || (rd_addr == ADR_HI)))
        |=> (rd_data == '0)); // R11

endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 64,
    parameter int EVT_NUM = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [REG_AW-1:0]  wr_addr,
    input  logic [REG_DW-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [REG_AW-1:0]  rd_addr,
    output logic [REG_DW-1:0]  rd_data,
    input  logic [EVT_NUM-1:0] evt_i
);

    ctl_t                          ctl;
    logic                          clr;
    evcfg_t [NUM_CNT-1:0]          cfg;
    logic   [NUM_CNT-1:0]          cfg_wr;
    logic   [SEL_W-1:0]            sel;
    logic   [NUM_CNT-1:0]          hit;
    logic   [NUM_CNT-1:0][CNT_W-1:0] cnt;
    logic                          run;

    assign run = ctl.en && ctl.go;

    evcnt_regs #(.NUM_CNT(NUM_CNT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctl_o    (ctl),
        .clr_o    (clr),
        .cfg_o    (cfg),
        .cfg_wr_o (cfg_wr),
        .sel_o    (sel)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_det
        evcnt_detect #(.EVT_NUM(EVT_NUM)) u_det (
            .clk      (clk),
            .rst      (rst),
            .evt_i    (evt_i),
            .cfg_i    (cfg[g]),
            .cfg_wr_i (cfg_wr[g]),
            .hit_o    (hit[g])
        );

        AST_FOREIGN_ID_SILENT: assert property (@(posedge clk) disable iff (rst)
            (int'(cfg[g].id) >= EVT_NUM) |-> !hit[g]); // R8
    end

    evcnt_counters #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run_i (run),
        .clr_i (clr),
        .hit_i (hit),
        .cnt_o (cnt)
    );

    evcnt_readout #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .ctl_i   (ctl),
        .cfg_i   (cfg),
        .sel_i   (sel),
        .cnt_i   (cnt),
        .rd_data (rd_data)
    );

endmodule

// File: tb/evt_counter_bank_test.sv
module evt_counter_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_CTL = 12'h108;
    localparam logic [11:0] A_SEL = 12'h12C;
    localparam logic [11:0] A_LO  = 12'h130;
    localparam logic [11:0] A_HI  = 12'h134;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [11:0]  wr_addr;
    logic [31:0]  wr_data;
    logic         rd_en;
    logic [11:0]  rd_addr;
    logic [31:0]  rd_data;
    logic [511:0] evt;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    logic rd_pend = 1'b0;
    logic done    = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    evt_counter_bank uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .evt_i   (evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rd_pend <= rd_en;
    end

    // monitor: compares each returned read word against the scoreboard
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            tests++;
            if (rd_data !== e) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", t, rd_data, e);
            end
        end
    end

    function automatic logic [11:0] cfg_a(input int i);
        return 12'h10C + 12'(4 * i);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int ta, tb, c7v;
        logic [31:0] expc [8];
        string rtag [8];
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_en = 1'b0; rd_addr = '0;
        evt = '0;
        evt[1] = 1'b1; evt[12'h105] = 1'b1; evt[12'h12D] = 1'b1;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        rd_chk(A_CTL, 32'h0, "R1 control after reset");
        rd_chk(cfg_a(0), 32'h0, "R1 cfg0 after reset");
        rd_chk(cfg_a(7), 32'h0, "R1 cfg7 after reset");
        rd_chk(A_SEL, 32'h0, "R1 select after reset");
        rd_chk(A_HI, 32'h0, "R11 high with select 0");
        rd_chk(A_LO, 32'h0, "R11 low with select 0");
        rd_chk(12'h100, 32'h0, "R12 unmapped offset");
        rd_chk(12'h200, 32'h0, "R12 unmapped offset high");

        // configuration
        wr(cfg_a(0), 32'h0000_0C3D);   // rising edge, line 0x3D
        wr(cfg_a(1), 32'h0000_0465);   // level high, line 0x65
        wr(cfg_a(2), 32'hFFFF_F905);   // falling edge, line 0x105
        wr(cfg_a(3), 32'h0000_012D);   // level low, line 0x12D
        wr(cfg_a(4), 32'h0000_063D);   // id 0x23D, outside the line range
        wr(cfg_a(5), 32'h0000_0DFF);   // rising edge, top line 0x1FF
        wr(cfg_a(6), 32'h0000_0400);   // level high, line 0 (kept low)
        wr(cfg_a(7), 32'h0000_0401);   // level high, line 1 (kept high)
        rd_chk(cfg_a(2), 32'h0000_0905, "R2 cfg2 upper bits dropped");
        rd_chk(cfg_a(5), 32'h0000_0DFF, "R2 cfg5 readback");

        // R3 partial control: enable only, then start only
        wr(A_SEL, 32'd15);
        wr(A_CTL, 32'h1); step(3);
        wr(A_CTL, 32'h2); step(3);
        wr(A_CTL, 32'h0);
        rd_chk(A_HI, 32'h0, "R3 counter7 high idle");
        rd_chk(A_LO, 32'h0, "R3 counter7 idle with partial control");

        // run window
        wr(A_CTL, 32'h3); ta = cyc;
        rd_chk(A_CTL, 32'h3, "R3 control readback");
        evt[12'h03D] = 1'b1; evt[12'h1FF] = 1'b1; step(1);
        evt[12'h03D] = 1'b0; evt[12'h1FF] = 1'b0; step(1);
        evt[12'h03D] = 1'b1; step(3);
        evt[12'h03D] = 1'b0; evt[12'h1FF] = 1'b1; step(1);
        evt[12'h1FF] = 1'b0; step(1);
        evt[12'h1FF] = 1'b1; step(1);
        evt[12'h1FF] = 1'b0; step(1);
        evt[12'h065] = 1'b1; step(5);
        evt[12'h065] = 1'b0; step(1);
        evt[12'h105] = 1'b0; step(2);
        evt[12'h105] = 1'b1; step(1);
        evt[12'h105] = 1'b0; step(1);
        evt[12'h105] = 1'b1; step(1);
        evt[12'h12D] = 1'b0; step(4);
        evt[12'h12D] = 1'b1; step(1);
        wr(A_CTL, 32'h0); tb = cyc;

        // activity while stopped must not count (R3)
        evt[12'h03D] = 1'b1; evt[12'h065] = 1'b1; step(3);
        evt[12'h03D] = 1'b0; evt[12'h065] = 1'b0; step(1);

        expc[0] = 32'd2; rtag[0] = "R5 rising edges on counter0";
        expc[1] = 32'd5; rtag[1] = "R7 level high on counter1";
        expc[2] = 32'd2; rtag[2] = "R6 falling edges on counter2";
        expc[3] = 32'd4; rtag[3] = "R7 level low on counter3";
        expc[4] = 32'd0; rtag[4] = "R8 out of range id on counter4";
        expc[5] = 32'd3; rtag[5] = "R5 rising edges on top line counter5";
        expc[6] = 32'd0; rtag[6] = "R7 level high idle line counter6";
        expc[7] = 32'(tb - ta); rtag[7] = "R3 run window length counter7";
        for (int i = 0; i < 8; i++) begin
            wr(A_SEL, 32'(8 + i));
            rd_chk(A_HI, 32'h0, "R9 high word");
            rd_chk(A_LO, expc[i], rtag[i]);
        end

        // R11 select outside window
        wr(A_SEL, 32'd16);
        rd_chk(A_HI, 32'h0, "R11 high select 16");
        rd_chk(A_LO, 32'h0, "R11 low select 16");
        wr(A_SEL, 32'd7);
        rd_chk(A_HI, 32'h0, "R11 high select 7");
        rd_chk(A_LO, 32'h0, "R11 low select 7");
        rd_chk(A_SEL, 32'd7, "R9 select readback");

        // R10 capture survives a select change
        wr(A_SEL, 32'd9);
        rd_chk(A_HI, 32'h0, "R10 high counter1");
        wr(A_SEL, 32'd10);
        rd_chk(A_LO, 32'd5, "R10 low keeps captured counter1");

        // R10 capture survives counting
        c7v = tb - ta;
        wr(A_SEL, 32'd15);
        rd_chk(A_HI, 32'h0, "R10 high counter7");
        wr(A_CTL, 32'h3); ta = cyc;
        step(3);
        wr(A_CTL, 32'h0); tb = cyc;
        rd_chk(A_LO, 32'(c7v), "R10 low not refreshed by counting");
        rd_chk(A_HI, 32'h0, "R9 high counter7 again");
        rd_chk(A_LO, 32'(c7v + tb - ta), "R3 counter7 after second window");

        // R4 global clear
        wr(A_CTL, 32'h10);
        rd_chk(A_CTL, 32'h0, "R4 clear bit self-clears");
        wr(A_SEL, 32'd8);
        rd_chk(A_HI, 32'h0, "R4 counter0 high");
        rd_chk(A_LO, 32'h0, "R4 counter0 cleared");
        wr(A_SEL, 32'd9);
        rd_chk(A_HI, 32'h0, "R4 counter1 high");
        rd_chk(A_LO, 32'h0, "R4 counter1 cleared");
        wr(A_SEL, 32'd15);
        rd_chk(A_HI, 32'h0, "R4 counter7 high");
        rd_chk(A_LO, 32'h0, "R4 counter7 cleared");
        wr(A_CTL, 32'h13); ta = cyc;
        rd_chk(A_CTL, 32'h3, "R4 clear with run keeps enable and start");
        step(2);
        wr(A_CTL, 32'h0); tb = cyc;
        rd_chk(A_HI, 32'h0, "R4 counter7 high after restart");
        rd_chk(A_LO, 32'(tb - ta), "R4 counter7 counts from zero");

        step(3);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule